// File: doc/BRIEF.md
# Dual-Channel DMA Handshake Controller

This block is the slave side of a DMA handshake between an external system DMA master and two internal word buffers: one serving the host-side engine and one serving the device-side engine. Each channel holds a request high while it is armed, and the master answers with an acknowledge. Every cycle in which request and acknowledge are both high moves one 16-bit word, either from the master into the buffer or from the buffer out to the master, as the channel's direction bit selects.

A transfer stops on an external end-of-transfer input that arrives with an acknowledged word, or, on the host channel only, when an internal byte counter reaches a programmed transfer count. Software sets the channels up through a small parallel register port. It first writes a command code with the address line high, then reads or writes 16-bit data with the address line low. Read and write codes for the same register differ only in bit 7.

Top module: `dmahs_ctrl`

## Requirements
- R1: After reset both requests are low, every configuration field, done flag, the transfer count and the byte counter are zero, and a register read returns zero.
- R2: A write with `reg_a0`=1 latches `reg_wdata[7:0]` as the command. A data write (`reg_a0`=0) under command 0xA1 loads the configuration, and under 0xA2 it loads the transfer count. A data read under 0x21 returns the configuration view, and under 0x22 it returns the transfer count. Any other command changes nothing. `reg_rdata` is zero unless `reg_cs`, `reg_rd` and `reg_a0`=0 are all present with code 0x21 or 0x22.
- R3: Configuration view bits: 0 enables the host channel, 1 enables the device channel, 2 enables the byte counter, 3 is the host direction, 4 is the device direction (1 = master writes into the buffer, 0 = master reads from it). Bit 8 is the host done flag and bit 9 the device done flag; both are read-only. All other bits read zero.
- R4: A channel's request is high exactly when the channel is enabled, not done, and (on the host channel with the counter on) the byte counter is below the transfer count.
- R5: An acknowledge taken while the request is high pulses that buffer's write strobe with `buf_wdata` = `dma_wdata` (direction 1), or pulses its read strobe and drives `dma_rdata` from the buffer's read data (direction 0), in the same cycle. An acknowledge without a request moves nothing, and `dma_rdata` is zero.
- R6: With the counter enabled, each host word adds 2 to the byte counter. The word that takes the counter to or past the transfer count is the last one: the done flag is set and the request is low from the next cycle.
- R7: `dma_eot` high together with an accepted word ends that channel after the word completes: the done flag is set and the request is low from the next cycle. `dma_eot` without an accepted word is ignored.
- R8: Arming the host channel with the counter on and a transfer count of zero raises no request at all, and the done flag is set one cycle after arming.
- R9: When the external end and the internal count end fall on the same host word, that word moves once, the counter advances by 2 once, and the transfer ends once.
- R10: A configuration write that sets a channel's enable clears its done flag and, for the host channel, resets the byte counter to zero. A write that clears the enable drops the request from the next cycle and leaves the done flag as it was.
- R11: The counter enable has no effect on the device channel; it ends only through `dma_eot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_cs | input | 1 | Register port select |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_a0 | input | 1 | 1 = command phase, 0 = data phase |
| reg_wdata | input | 16 | Register write data or command code |
| reg_rdata | output | 16 | Register read data |
| dma_req_h | output | 1 | Host channel request |
| dma_ack_h | input | 1 | Host channel acknowledge |
| dma_req_d | output | 1 | Device channel request |
| dma_ack_d | input | 1 | Device channel acknowledge |
| dma_eot | input | 1 | External end-of-transfer |
| dma_wdata | input | 16 | Word from the DMA master |
| dma_rdata | output | 16 | Word to the DMA master |
| hbuf_we | output | 1 | Host buffer write strobe |
| hbuf_re | output | 1 | Host buffer read strobe |
| hbuf_wdata | output | 16 | Host buffer write data |
| hbuf_rdata | input | 16 | Host buffer read data |
| dbuf_we | output | 1 | Device buffer write strobe |
| dbuf_re | output | 1 | Device buffer read strobe |
| dbuf_wdata | output | 16 | Device buffer write data |
| dbuf_rdata | input | 16 | Device buffer read data |

## Verification
The hardest case to reach from the ports is the host word on which the external end and the counter end land together. The only way to create it is to program a transfer count, arm the channel, and then pair `dma_eot` with exactly the acknowledge that carries the counter to that count. The bench does this, then rearms and runs a full count without `dma_eot` to show that the counter restarted from zero. Zero-count arming and odd counts come from the same kind of programmed sequence. The reference model's request and strobe predictions are compared in every cycle, so a stray request or a second word shows up at once.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;
    parameter int DATA_W = 16;
    parameter int CNT_W  = 16;
    parameter int CMD_W  = 8;
    parameter int N_CH   = 2;

    localparam int STEP = DATA_W / 8;

    localparam logic [CMD_W-1:0] CMD_CFG_RD = 8'h21;
    localparam logic [CMD_W-1:0] CMD_CFG_WR = 8'hA1;
    localparam logic [CMD_W-1:0] CMD_TC_RD  = 8'h22;
    localparam logic [CMD_W-1:0] CMD_TC_WR  = 8'hA2;

    localparam int CFG_EN0   = 0;
    localparam int CFG_CNT   = N_CH;
    localparam int CFG_DIR0  = N_CH + 1;
    localparam int STS_DONE0 = 8;

    typedef struct packed {
        logic             en;
        logic             dir;
        logic             cnt_en;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [CNT_W-1:0] tc;
    } regp_st_t;
endpackage

// File: rtl/dmahs_regport.sv
module dmahs_regport
    import dmahs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_CH-1:0]   ch_en,
    input  logic [N_CH-1:0]   ch_dir,
    input  logic [N_CH-1:0]   ch_done,
    input  logic              cnt_en,
    output logic              cfg_we,
    output logic [CNT_W-1:0]  tc,
    output logic [DATA_W-1:0] rdata
);
    regp_st_t          rp_d, rp_q;
    logic [DATA_W-1:0] view;

    always_comb begin
        rp_d = rp_q;
        if (cs && wr) begin
            if (a0) begin
                rp_d.cmd = wdata[CMD_W-1:0];
            end else if (rp_q.cmd == CMD_TC_WR) begin
                rp_d.tc = CNT_W'(wdata);
            end
        end
        cfg_we = cs && wr && !a0 && (rp_q.cmd == CMD_CFG_WR);

        view = '0;
        for (int k = 0; k < N_CH; k++) begin
            view[CFG_EN0 + k]   = ch_en[k];
            view[CFG_DIR0 + k]  = ch_dir[k];
            view[STS_DONE0 + k] = ch_done[k];
        end
        view[CFG_CNT] = cnt_en;

        rdata = '0;
        if (cs && rd && !a0) begin
            case (rp_q.cmd)
                CMD_CFG_RD: rdata = view;
                CMD_TC_RD:  rdata = DATA_W'(rp_q.tc);
                default:    rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign tc = rp_q.tc;
endmodule

// File: rtl/dmahs_chan.sv
module dmahs_chan
    import dmahs_pkg::*;
#(
    parameter bit USE_CNT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic             cfg_dir,
    input  logic             cfg_cnt,
    input  logic [CNT_W-1:0] tc,
    input  logic             dack,
    input  logic             eot,
    output logic             req,
    output logic             xfer,
    output logic             en,
    output logic             dir,
    output logic             done,
    output logic             cnt_en,
    output logic [CNT_W-1:0] cnt
);
    chan_st_t         st_d, st_q;
    logic             hit;
    logic [CNT_W:0]   cnt_nx;

    always_comb begin
        st_d   = st_q;
        hit    = st_q.cnt_en && (st_q.cnt >= tc);
        req    = st_q.en && !st_q.done && !hit;
        xfer   = req && dack;
        cnt_nx = {1'b0, st_q.cnt} + (CNT_W+1)'(STEP);

        if (cfg_we) begin
            st_d.en     = cfg_en;
            st_d.dir    = cfg_dir;
            st_d.cnt_en = cfg_cnt && USE_CNT;
            if (cfg_en) begin
                st_d.done = 1'b0;
                st_d.cnt  = '0;
            end
        end else if (xfer) begin
            if (st_q.cnt_en) st_d.cnt = cnt_nx[CNT_W-1:0];
            if (eot || (st_q.cnt_en && (cnt_nx >= {1'b0, tc}))) st_d.done = 1'b1;
        end else if (st_q.en && !st_q.done && hit) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en     = st_q.en;
    assign dir    = st_q.dir;
    assign done   = st_q.done;
    assign cnt_en = st_q.cnt_en;
    assign cnt    = st_q.cnt;
endmodule

// File: rtl/dmahs_ctrl.sv
module dmahs_ctrl
    import dmahs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_cs,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_a0,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dma_req_h,
    input  logic              dma_ack_h,
    output logic              dma_req_d,
    input  logic              dma_ack_d,
    input  logic              dma_eot,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              hbuf_we,
    output logic              hbuf_re,
    output logic [DATA_W-1:0] hbuf_wdata,
    input  logic [DATA_W-1:0] hbuf_rdata,
    output logic              dbuf_we,
    output logic              dbuf_re,
    output logic [DATA_W-1:0] dbuf_wdata,
    input  logic [DATA_W-1:0] dbuf_rdata
);
    logic                         cfg_we;
    logic [CNT_W-1:0]             tc_q;
    logic [N_CH-1:0]              ch_ack, ch_req, ch_xfer, ch_en, ch_dir, ch_done, ch_cnt_en;
    logic [N_CH-1:0][CNT_W-1:0]   ch_cnt;
    logic [N_CH-1:0]              buf_we, buf_re;
    logic [N_CH-1:0][DATA_W-1:0]  buf_rd;

    assign ch_ack = {dma_ack_d, dma_ack_h};
    assign buf_rd = {dbuf_rdata, hbuf_rdata};

    dmahs_regport u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (reg_cs),
        .rd      (reg_rd),
        .wr      (reg_wr),
        .a0      (reg_a0),
        .wdata   (reg_wdata),
        .ch_en   (ch_en),
        .ch_dir  (ch_dir),
        .ch_done (ch_done),
        .cnt_en  (ch_cnt_en[0]),
        .cfg_we  (cfg_we),
        .tc      (tc_q),
        .rdata   (reg_rdata)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dmahs_chan #(.USE_CNT(g == 0)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we),
            .cfg_en  (reg_wdata[CFG_EN0 + g]),
            .cfg_dir (reg_wdata[CFG_DIR0 + g]),
            .cfg_cnt (reg_wdata[CFG_CNT]),
            .tc      (tc_q),
            .dack    (ch_ack[g]),
            .eot     (dma_eot),
            .req     (ch_req[g]),
            .xfer    (ch_xfer[g]),
            .en      (ch_en[g]),
            .dir     (ch_dir[g]),
            .done    (ch_done[g]),
            .cnt_en  (ch_cnt_en[g]),
            .cnt     (ch_cnt[g])
        );
        assign buf_we[g] = ch_xfer[g] && ch_dir[g];
        assign buf_re[g] = ch_xfer[g] && !ch_dir[g];
    end

    always_comb begin
        dma_rdata = '0;
        for (int k = N_CH - 1; k >= 0; k--) begin
            if (buf_re[k]) dma_rdata = buf_rd[k];
        end
    end

    assign dma_req_h  = ch_req[0];
    assign dma_req_d  = ch_req[1];
    assign hbuf_we    = buf_we[0];
    assign hbuf_re    = buf_re[0];
    assign dbuf_we    = buf_we[1];
    assign dbuf_re    = buf_re[1];
    assign hbuf_wdata = dma_wdata;
    assign dbuf_wdata = dma_wdata;
endmodule

// File: rtl/dmahs_chk.sv
module dmahs_chk
    import dmahs_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic [CNT_W-1:0]            tc_q,
    input logic                        dma_req_h,
    input logic                        dma_ack_h,
    input logic                        dma_req_d,
    input logic                        dma_ack_d,
    input logic                        dma_eot,
    input logic                        hbuf_we,
    input logic                        hbuf_re,
    input logic                        dbuf_we,
    input logic                        dbuf_re,
    input logic [N_CH-1:0]             ch_done,
    input logic [N_CH-1:0]             ch_cnt_en,
    input logic [N_CH-1:0][CNT_W-1:0]  ch_cnt
);
    AST_NO_REQ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !((ch_done[0] && dma_req_h) || (ch_done[1] && dma_req_d))); // R4

    AST_HSTROBE_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (hbuf_we || hbuf_re) |-> (dma_ack_h && dma_req_h && !(hbuf_we && hbuf_re))); // R5

    AST_DSTROBE_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_we || dbuf_re) |-> (dma_ack_d && dma_req_d && !(dbuf_we && dbuf_re))); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_h && dma_ack_h && ch_cnt_en[0] && !cfg_we)
        |=> (ch_cnt[0] == $past(ch_cnt[0]) + CNT_W'(STEP))); // R6

    AST_EOT_ENDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_h && dma_ack_h && dma_eot && !cfg_we) |=> !dma_req_h); // R7

    AST_EOT_ENDS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_d && dma_ack_d && dma_eot && !cfg_we) |=> !dma_req_d); // R7

    AST_ZERO_COUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && reg_wdata[CFG_EN0] && reg_wdata[CFG_CNT] && (tc_q == '0)) |=> !dma_req_h); // R8

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && reg_wdata[CFG_EN0]) |=> (!ch_done[0] && (ch_cnt[0] == '0))); // R10

    AST_DEV_NO_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_cnt_en[1]); // R11
endmodule

bind dmahs_ctrl dmahs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .reg_wdata (reg_wdata),
    .tc_q      (tc_q),
    .dma_req_h (dma_req_h),
    .dma_ack_h (dma_ack_h),
    .dma_req_d (dma_req_d),
    .dma_ack_d (dma_ack_d),
    .dma_eot   (dma_eot),
    .hbuf_we   (hbuf_we),
    .hbuf_re   (hbuf_re),
    .dbuf_we   (dbuf_we),
    .dbuf_re   (dbuf_re),
    .ch_done   (ch_done),
    .ch_cnt_en (ch_cnt_en),
    .ch_cnt    (ch_cnt)
);

// File: tb/sim_dmahs_ctrl.sv
module sim_dmahs_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_cs = 0, reg_rd = 0, reg_wr = 0, reg_a0 = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dma_req_h, dma_req_d;
    logic        dma_ack_h = 0, dma_ack_d = 0, dma_eot = 0;
    logic [15:0] dma_wdata = '0, dma_rdata;
    logic        hbuf_we, hbuf_re, dbuf_we, dbuf_re;
    logic [15:0] hbuf_wdata, dbuf_wdata;
    logic [15:0] hbuf_rdata = '0, dbuf_rdata = '0;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    string tag  = "R1";

    // reference model state
    int  m_cmd, m_tc, m_cnt;
    bit  m_en[2], m_dir[2], m_done[2];
    bit  m_cnten;

    always #2 clk = ~clk;

    dmahs_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_cs(reg_cs), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_a0(reg_a0),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_req_h(dma_req_h), .dma_ack_h(dma_ack_h),
        .dma_req_d(dma_req_d), .dma_ack_d(dma_ack_d),
        .dma_eot(dma_eot), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .hbuf_we(hbuf_we), .hbuf_re(hbuf_re), .hbuf_wdata(hbuf_wdata), .hbuf_rdata(hbuf_rdata),
        .dbuf_we(dbuf_we), .dbuf_re(dbuf_re), .dbuf_wdata(dbuf_wdata), .dbuf_rdata(dbuf_rdata)
    );

    task automatic model_reset();
        m_cmd = 0; m_tc = 0; m_cnt = 0; m_cnten = 0;
        for (int k = 0; k < 2; k++) begin
            m_en[k] = 0; m_dir[k] = 0; m_done[k] = 0;
        end
    endtask

    function automatic bit exp_req(int ch);
        if (ch == 0) return m_en[0] && !m_done[0] && !(m_cnten && m_cnt >= m_tc);
        return m_en[1] && !m_done[1];
    endfunction

    task automatic chk1(string what, int act, int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
            bad = 1;
        end
    endtask

    task automatic compare();
        bit bad = 0;
        bit xh, xd;
        int view, rexp, dexp;
        xh = exp_req(0) && dma_ack_h;
        xd = exp_req(1) && dma_ack_d;
        view = 0;
        view |= m_en[0] ? 32'h1 : 0;
        view |= m_en[1] ? 32'h2 : 0;
        view |= m_cnten ? 32'h4 : 0;
        view |= m_dir[0] ? 32'h8 : 0;
        view |= m_dir[1] ? 32'h10 : 0;
        view |= m_done[0] ? 32'h100 : 0;
        view |= m_done[1] ? 32'h200 : 0;
        rexp = 0;
        if (reg_cs && reg_rd && !reg_a0) begin
            if (m_cmd == 'h21) rexp = view;
            else if (m_cmd == 'h22) rexp = m_tc;
        end
        dexp = 0;
        if (xh && !m_dir[0]) dexp = hbuf_rdata;
        else if (xd && !m_dir[1]) dexp = dbuf_rdata;
        chk1("dma_req_h", dma_req_h, exp_req(0), bad);
        chk1("dma_req_d", dma_req_d, exp_req(1), bad);
        chk1("hbuf_we", hbuf_we, xh && m_dir[0], bad);
        chk1("hbuf_re", hbuf_re, xh && !m_dir[0], bad);
        chk1("dbuf_we", dbuf_we, xd && m_dir[1], bad);
        chk1("dbuf_re", dbuf_re, xd && !m_dir[1], bad);
        chk1("reg_rdata", reg_rdata, rexp, bad);
        chk1("dma_rdata", dma_rdata, dexp, bad);
        if (xh && m_dir[0]) chk1("hbuf_wdata", hbuf_wdata, dma_wdata, bad);
        if (xd && m_dir[1]) chk1("dbuf_wdata", dbuf_wdata, dma_wdata, bad);
        vectors++;
        if (bad) fails++;
    endtask

    task automatic model_update();
        bit xh, xd, hit;
        hit = m_cnten && m_cnt >= m_tc;
        xh = exp_req(0) && dma_ack_h;
        xd = exp_req(1) && dma_ack_d;
        if (reg_cs && reg_wr && !reg_a0 && m_cmd == 'hA1) begin
            m_cnten = reg_wdata[2];
            for (int k = 0; k < 2; k++) begin
                m_en[k]  = reg_wdata[k];
                m_dir[k] = reg_wdata[3 + k];
                if (reg_wdata[k]) begin
                    m_done[k] = 0;
                    if (k == 0) m_cnt = 0;
                end
            end
        end else begin
            if (xh) begin
                if (m_cnten) m_cnt += 2;
                if (dma_eot || (m_cnten && m_cnt >= m_tc)) m_done[0] = 1;
            end else if (m_en[0] && !m_done[0] && hit) begin
                m_done[0] = 1;
            end
            if (xd && dma_eot) m_done[1] = 1;
        end
        if (reg_cs && reg_wr && !reg_a0 && m_cmd == 'hA2) m_tc = reg_wdata;
        if (reg_cs && reg_wr && reg_a0) m_cmd = reg_wdata[7:0];
    endtask

    task automatic step();
        #1;
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic clr();
        reg_cs = 0; reg_rd = 0; reg_wr = 0; reg_a0 = 0; reg_wdata = '0;
        dma_ack_h = 0; dma_ack_d = 0; dma_eot = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic reg_write(logic [7:0] cmd, logic [15:0] data);
        reg_cs = 1; reg_wr = 1; reg_a0 = 1; reg_wdata = {8'h00, cmd};
        step();
        reg_a0 = 0; reg_wdata = data;
        step();
        clr();
    endtask

    task automatic reg_read(logic [7:0] cmd);
        reg_cs = 1; reg_wr = 1; reg_a0 = 1; reg_wdata = {8'h00, cmd};
        step();
        reg_wr = 0; reg_rd = 1; reg_a0 = 0; reg_wdata = '0;
        step();
        clr();
    endtask

    task automatic word(bit ah, bit ad, bit e, logic [15:0] d);
        dma_ack_h = ah; dma_ack_d = ad; dma_eot = e;
        dma_wdata = d; hbuf_rdata = d ^ 16'h5A5A; dbuf_rdata = d ^ 16'hA5A5;
        step();
        clr();
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        fails++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        model_reset();
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        tag = "R1"; idle(2); reg_read(8'h21); reg_read(8'h22);

        tag = "R2"; reg_write(8'hA2, 16'd6); reg_read(8'h22);
        reg_write(8'h55, 16'hFFFF); reg_read(8'h21); reg_read(8'h22);
        reg_cs = 1; reg_rd = 1; reg_a0 = 1; step(); clr();

        // host channel, master writes, counter on, count 6 -> three words
        tag = "R6"; reg_write(8'hA1, 16'h000D); reg_read(8'h21); idle(3);
        for (int i = 0; i < 3; i++) word(1, 0, 0, 16'h1000 + 16'(i));
        tag = "R5"; word(1, 0, 0, 16'hDEAD); word(1, 0, 0, 16'hBEEF);
        tag = "R6"; reg_read(8'h21);

        // same-word external and internal end
        tag = "R9"; reg_write(8'hA2, 16'd4); reg_write(8'hA1, 16'h000D);
        word(1, 0, 0, 16'h2001); word(1, 0, 1, 16'h2002); idle(2); reg_read(8'h21);
        tag = "R10"; reg_write(8'hA1, 16'h000D); reg_read(8'h21);
        word(1, 0, 0, 16'h2101); word(1, 0, 0, 16'h2102); word(1, 0, 0, 16'h2103);

        // odd count: ends on the word passing it
        tag = "R6"; reg_write(8'hA2, 16'd3); reg_write(8'hA1, 16'h000D);
        word(1, 0, 0, 16'h3001); word(1, 0, 0, 16'h3002); word(1, 0, 0, 16'h3003);

        tag = "R8"; reg_write(8'hA2, 16'd0); reg_write(8'hA1, 16'h000D);
        idle(3); word(1, 0, 0, 16'h4001); reg_read(8'h21);

        // device channel, master reads, counter bit set but ignored
        tag = "R11"; reg_write(8'hA1, 16'h0006); idle(2); reg_read(8'h21);
        tag = "R5"; for (int i = 0; i < 3; i++) word(0, 1, 0, 16'h5000 + 16'(i));
        tag = "R7"; word(0, 0, 1, 16'h5100); word(1, 0, 1, 16'h5101); idle(1);
        word(0, 1, 1, 16'h5102); word(0, 1, 0, 16'h5103); reg_read(8'h21);

        // host channel, master reads, external end only
        tag = "R7"; reg_write(8'hA1, 16'h0001);
        for (int i = 0; i < 4; i++) word(1, 0, 0, 16'h6000 + 16'(i));
        word(1, 0, 1, 16'h6004); word(1, 0, 0, 16'h6005); reg_read(8'h21);

        // disable mid-transfer keeps done flags
        tag = "R10"; reg_write(8'hA1, 16'h0012); word(0, 1, 0, 16'h7000);
        reg_write(8'hA1, 16'h0000); idle(2); word(0, 1, 0, 16'h7001); reg_read(8'h21);

        tag = "R3"; reg_write(8'hA1, 16'hFFE3); reg_read(8'h21); idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule